// File: doc/BRIEF.md
# Cascadable One-Position Shift Slice

This block is a purely combinational shifter slice of parameterised width, six bits by default. A two-bit select chooses one of four operations on the data word: leave it unchanged, move it one position toward the most significant end, move it one position toward the least significant end, or clear it. There is no clock and no storage. The outputs follow the data, select and fill inputs directly.

Every slice has two serial inputs and two serial outputs. When the word moves toward the MSB, the vacated LSB is taken from the low-side fill input, and the bit pushed out of the MSB appears on the high-side serial output. A right shift mirrors this. The serial outputs of one slice are wired to the fill inputs of its neighbours, so that identical slices form a wider shifter. With the outermost fill inputs tied to 0, a chain of k slices behaves exactly like a single logical shifter of k×WIDTH bits.

Top module: `shift_slice`

## Requirements
- R1: With select code 0 (pass), `dout` equals `din`, and both `ser_msb_out` and `ser_lsb_out` are 0.
- R2: With select code 1 (shift toward MSB), `dout[i]` equals `din[i-1]` for i ≥ 1, and `dout[0]` equals `ser_lsb_in`.
- R3: With select code 1, `ser_msb_out` equals `din[WIDTH-1]` and `ser_lsb_out` is 0.
- R4: With select code 2 (shift toward LSB), `dout[i]` equals `din[i+1]` for i < WIDTH-1, and `dout[WIDTH-1]` equals `ser_msb_in`.
- R5: With select code 2, `ser_lsb_out` equals `din[0]` and `ser_msb_out` is 0.
- R6: With select code 3 (clear), `dout` is all zeros and both serial outputs are 0, whatever the values of `din` and of both fill inputs.
- R7: The outputs are a combinational function of the inputs. A change on `din`, `sel` or a fill input shows at the outputs without any clock edge.
- R8: Two slices can be chained: the upper slice's `ser_lsb_in` is driven by the lower slice's `ser_msb_out`, and the lower slice's `ser_msb_in` is driven by the upper slice's `ser_lsb_out`. The chain's 2×WIDTH result then equals a single 2×WIDTH shifter, using the outer fill inputs. With those tied to 0, this is a plain logical shift.
- R9: The two serial outputs are never 1 at the same time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| din | input | WIDTH | Data word to operate on |
| sel | input | 2 | Operation: 0 pass, 1 shift toward MSB, 2 shift toward LSB, 3 clear |
| ser_lsb_in | input | 1 | Bit fed into the LSB on a shift toward the MSB |
| ser_msb_in | input | 1 | Bit fed into the MSB on a shift toward the LSB |
| dout | output | WIDTH | Resulting data word |
| ser_msb_out | output | 1 | Bit pushed out of the MSB on a shift toward the MSB, else 0 |
| ser_lsb_out | output | 1 | Bit pushed out of the LSB on a shift toward the LSB, else 0 |

## Verification
In one evaluation, the bit-wise data move and the serial boundary transfer take place together. A fill bit enters at one end of the word while the opposite end bit leaves through a serial output, and in a chain the bit that leaves one slice becomes the fill of its neighbour. The bench provokes this by driving all four fill combinations with each select code, both on a lone slice and on a two-slice chain. It judges the full result, meaning the data word and both serial outputs, against a bench reference shifter of the matching total width. Clear mode is driven with fills set to 1 so that any leakage from the fill inputs would show at the outputs.

// File: rtl/shift_slice_pkg.sv
// Package: shared types for the shift slice.
// Assumes: select encoding is fixed by the chaining behaviour.
package shift_slice_pkg;

    typedef enum logic [1:0] {
        OP_PASS  = 2'd0,
        OP_SHL   = 2'd1,
        OP_SHR   = 2'd2,
        OP_CLEAR = 2'd3
    } shift_op_e;

    typedef struct packed {
        logic keep;   // take own bit
        logic up;     // take bit from lower neighbour (shift toward MSB)
        logic down;   // take bit from upper neighbour (shift toward LSB)
    } shift_ctrl_t;

endpackage

// File: rtl/shift_mode_dec.sv
// Module: turns the 2-bit select into one-hot lane controls.
// Assumes: clear mode is encoded as no control active.
module shift_mode_dec
    import shift_slice_pkg::*;
(
    input  logic [1:0]  sel,
    output shift_ctrl_t ctrl
);

    // decode select into lane enables
    always_comb begin
        ctrl = '0;
        unique case (shift_op_e'(sel))
            OP_PASS:  ctrl.keep = 1'b1;
            OP_SHL:   ctrl.up   = 1'b1;
            OP_SHR:   ctrl.down = 1'b1;
            default:  ctrl      = '0;
        endcase
    end

    // R6: at most one lane enable, none in clear mode
    always_comb begin
        a_r6_ctrl_onehot: assert ($onehot0({ctrl.keep, ctrl.up, ctrl.down}));
    end

endmodule

// File: rtl/shift_bit_cell.sv
// Module: one bit lane, choosing own, lower or upper neighbour bit.
// Assumes: controls are one-hot or all zero; all zero yields 0.
module shift_bit_cell
    import shift_slice_pkg::*;
(
    input  shift_ctrl_t ctrl,
    input  logic        own_bit,
    input  logic        lower_bit,
    input  logic        upper_bit,
    output logic        y
);

    // AND-OR select of the lane source
    always_comb begin
        y = (ctrl.keep & own_bit) | (ctrl.up & lower_bit) | (ctrl.down & upper_bit);
    end

endmodule

// File: rtl/shift_edge_out.sv
// Module: forms the two serial outputs from the word's end bits.
// Assumes: controls come from shift_mode_dec.
module shift_edge_out
    import shift_slice_pkg::*;
#(
    parameter int WIDTH = 6
) (
    input  shift_ctrl_t      ctrl,
    input  logic [WIDTH-1:0] din,
    output logic             msb_out,
    output logic             lsb_out
);

    localparam int MSB = WIDTH - 1;

    // push out the end bit only in the matching shift direction
    always_comb begin
        msb_out = ctrl.up   & din[MSB];
        lsb_out = ctrl.down & din[0];
    end

endmodule

// File: rtl/shift_slice.sv
// Module: cascadable one-position shift slice (pass/left/right/clear).
// Assumes: WIDTH >= 2; neighbours link serial outputs to fill inputs.
module shift_slice
    import shift_slice_pkg::*;
#(
    parameter int WIDTH = 6
) (
    input  logic [WIDTH-1:0] din,
    input  logic [1:0]       sel,
    input  logic             ser_lsb_in,
    input  logic             ser_msb_in,
    output logic [WIDTH-1:0] dout,
    output logic             ser_msb_out,
    output logic             ser_lsb_out
);

    localparam int MSB = WIDTH - 1;

    shift_ctrl_t      ctrl;
    logic [WIDTH+1:0] ext;   // {ser_msb_in, din, ser_lsb_in}

    // widen the word with the fill bits at both ends
    always_comb begin
        ext = {ser_msb_in, din, ser_lsb_in};
    end

    shift_mode_dec u_dec (
        .sel  (sel),
        .ctrl (ctrl)
    );

    for (genvar i = 0; i < WIDTH; i++) begin : g_lane
        shift_bit_cell u_cell (
            .ctrl      (ctrl),
            .own_bit   (ext[i+1]),
            .lower_bit (ext[i]),
            .upper_bit (ext[i+2]),
            .y         (dout[i])
        );
    end

    shift_edge_out #(.WIDTH(WIDTH)) u_edge (
        .ctrl    (ctrl),
        .din     (din),
        .msb_out (ser_msb_out),
        .lsb_out (ser_lsb_out)
    );

    // port-level guards across decoder, lanes and edge logic
    always_comb begin
        a_r9_serial_exclusive: assert ($onehot0({ser_msb_out, ser_lsb_out}));
        if (sel == OP_PASS) begin
            a_r1_pass_through: assert (dout == din && !ser_msb_out && !ser_lsb_out);
        end
        if (sel == OP_SHL) begin
            a_r3_left_serial: assert (ser_msb_out == din[MSB] && !ser_lsb_out);
            a_r2_left_fill: assert (dout[0] == ser_lsb_in);
        end
        if (sel == OP_SHR) begin
            a_r5_right_serial: assert (ser_lsb_out == din[0] && !ser_msb_out);
            a_r4_right_fill: assert (dout[MSB] == ser_msb_in);
        end
        if (sel == OP_CLEAR) begin
            a_r6_clear_zero: assert (dout == '0 && !ser_msb_out && !ser_lsb_out);
        end
    end

endmodule

// File: tb/test_shift_slice.sv
`timescale 1ns/1ps
// Bench: single slice plus a two-slice chain vs. a bench reference shifter.
module test_shift_slice;

    localparam int W  = 6;
    localparam int W2 = 2 * W;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;   // 125 MHz

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    // single slice
    logic [W-1:0] din;
    logic [1:0]   sel;
    logic         f_lsb, f_msb;
    logic [W-1:0] dout;
    logic         s_msb, s_lsb;

    shift_slice #(.WIDTH(W)) i_shift_slice (
        .din(din), .sel(sel), .ser_lsb_in(f_lsb), .ser_msb_in(f_msb),
        .dout(dout), .ser_msb_out(s_msb), .ser_lsb_out(s_lsb)
    );

    // two-slice chain
    logic [W2-1:0] c_din;
    logic [1:0]    c_sel;
    logic          c_f_lsb, c_f_msb;
    logic [W-1:0]  lo_out, hi_out;
    logic          lo_msb, lo_lsb, hi_msb, hi_lsb;

    shift_slice #(.WIDTH(W)) u_lo (
        .din(c_din[W-1:0]), .sel(c_sel), .ser_lsb_in(c_f_lsb), .ser_msb_in(hi_lsb),
        .dout(lo_out), .ser_msb_out(lo_msb), .ser_lsb_out(lo_lsb)
    );
    shift_slice #(.WIDTH(W)) u_hi (
        .din(c_din[W2-1:W]), .sel(c_sel), .ser_lsb_in(lo_msb), .ser_msb_in(c_f_msb),
        .dout(hi_out), .ser_msb_out(hi_msb), .ser_lsb_out(hi_lsb)
    );

    // reference: returns {msb_out, lsb_out, data[15:0]} for an n-bit shifter
    function automatic logic [17:0] ref_shift(input int n, input logic [15:0] d,
                                              input logic [1:0] s, input logic fl, input logic fm);
        logic [15:0] y;
        logic mo, lo;
        y = '0; mo = 1'b0; lo = 1'b0;
        for (int i = 0; i < n; i++) begin
            case (s)
                2'd0: y[i] = d[i];
                2'd1: y[i] = (i == 0) ? fl : d[i-1];
                2'd2: y[i] = (i == n-1) ? fm : d[i+1];
                default: y[i] = 1'b0;
            endcase
        end
        if (s == 2'd1) mo = d[n-1];
        if (s == 2'd2) lo = d[0];
        return {mo, lo, y};
    endfunction

    function automatic string req_of(input logic [1:0] s);
        case (s)
            2'd0: return "R1";
            2'd1: return "R2/R3";
            2'd2: return "R4/R5";
            default: return "R6";
        endcase
    endfunction

    task automatic check(input string req, input logic [17:0] got, input logic [17:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic run_single(input logic [W-1:0] d, input logic [1:0] s, input logic fl, input logic fm);
        @(negedge clk);
        din = d; sel = s; f_lsb = fl; f_msb = fm;
        #1;
        check(req_of(s), {s_msb, s_lsb, 10'd0, dout}, ref_shift(W, 16'(d), s, fl, fm));
        n_tests++;   // R9: serial outputs exclusive
        if (s_msb && s_lsb) begin
            n_fail++;
            $display("FAIL R9: got %b%b expected not both 1", s_msb, s_lsb);
        end
    endtask

    task automatic run_chain(input logic [W2-1:0] d, input logic [1:0] s, input logic fl, input logic fm);
        @(negedge clk);
        c_din = d; c_sel = s; c_f_lsb = fl; c_f_msb = fm;
        #1;
        check("R8", {hi_msb, lo_lsb, 4'd0, hi_out, lo_out}, ref_shift(W2, 16'(d), s, fl, fm));
    endtask

    initial begin
        int unused_seed;
        unused_seed = $urandom(32'h5eed_1234);
        din = '0; sel = '0; f_lsb = 0; f_msb = 0;
        c_din = '0; c_sel = '0; c_f_lsb = 0; c_f_msb = 0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;

        // initial state with all-zero inputs: pass of zero word
        @(negedge clk); #1;
        check("R1", {s_msb, s_lsb, 10'd0, dout}, 18'd0);

        // directed corners: every select x every fill combination
        for (int s = 0; s < 4; s++) begin
            for (int f = 0; f < 4; f++) begin
                run_single('1, 2'(s), f[0], f[1]);
                run_single('0, 2'(s), f[0], f[1]);
                run_single(6'b100001, 2'(s), f[0], f[1]);
                run_single(6'b010110, 2'(s), f[0], f[1]);
                run_chain('1, 2'(s), f[0], f[1]);
                run_chain(12'b100000_000001, 2'(s), f[0], f[1]);
            end
        end

        // R6: clear mode with fills high must give all zeros
        run_single('1, 2'd3, 1'b1, 1'b1);
        check("R6", {s_msb, s_lsb, 10'd0, dout}, 18'd0);

        // R7: outputs follow inputs within one clock period, no edge between
        @(negedge clk);
        din = 6'b000001; sel = 2'd1; f_lsb = 1'b1; f_msb = 1'b0;
        #1;
        check("R7", {s_msb, s_lsb, 10'd0, dout}, {2'b00, 10'd0, 6'b000011});
        din = 6'b100000;
        #1;
        check("R7", {s_msb, s_lsb, 10'd0, dout}, {2'b10, 10'd0, 6'b000001});
        sel = 2'd2; f_msb = 1'b1;
        #1;
        check("R7", {s_msb, s_lsb, 10'd0, dout}, {2'b00, 10'd0, 6'b110000});

        // R8: chain with outer fills tied to 0 is a 12-bit logical shift
        for (int k = 0; k < 150; k++) begin
            run_chain(12'($urandom), 2'($urandom), 1'b0, 1'b0);
        end

        // random mixed stimulus
        for (int k = 0; k < 300; k++) begin
            run_single(6'($urandom), 2'($urandom), 1'($urandom), 1'($urandom));
            run_chain(12'($urandom), 2'($urandom), 1'($urandom), 1'($urandom));
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule